// File: doc/BRIEF.md
# Interrupt Context Switch Sequencer

This block runs the memory traffic of a trap once an interrupt has been accepted. It reads a two-word vector that gives the new workspace pointer and the new program counter. It then saves the interrupted context into registers 13 to 15 of the new workspace, which live in memory. When the last store completes, it hands the new workspace pointer, the new program counter and the new status word to the processor. The status word keeps its upper bits, and its mask field is replaced by a value chosen for the trap.

The block also covers power-up. While reset is low it holds the processor and drives a reset code on its bus status output. When reset is released it starts a level-0 trap on its own. If a non-maskable request is pending when that trap finishes, the block fetches the first instruction of the level-0 routine but does not let it run. It then chains straight into a non-maskable trap. Accepting a maskable request needs both the arbiter's request and an instruction boundary from the processor. A non-maskable request at a boundary wins over a maskable one.

Top module: `ctx_switch_seq`

## Requirements
- R1: While rst_ni is low, bus_status_o is 3'b111, hold_o is 1, mem_rd_o, mem_wr_o and done_o are 0.
- R2: After rst_ni rises, a level-0 trap starts without waiting for instr_done_i, and its vector reads go to 0x0000 and 0x0002.
- R3: Every trap makes five accesses in a fixed order. It reads the workspace pointer at the vector address V, then the program counter at V+2. It then writes the old workspace pointer to W+26, the old program counter to W+28 and the old status to W+30, where W is the word read from V. The old context is cur_*_i as sampled on the cycle the trap is accepted. mem_rd_o and mem_wr_o are never high together.
- R4: Each access keeps its strobe, address and write data steady until mem_rdy_i is sampled high on a rising edge, and only then moves to the next access.
- R5: A maskable request is accepted only when the block is idle and req_i and instr_done_i are both high. Its vector address is req_level_i*4.
- R6: nmi_i high at an instruction boundary starts a trap through vector 0xFFFC/0xFFFE and takes priority over req_i. The mask it loads is 0.
- R7: done_o is a one-cycle pulse in the cycle after the ready of the W+30 write. new_wp_o and new_pc_o are the two vector words. new_st_o is the old status with bits [3:0] replaced by the mask: req_mask_i for a maskable trap, 0 for level-0 and non-maskable traps.
- R8: If nmi_i is high when the level-0 trap's last write completes, one read at the new program counter follows with bus_status_o 3'b001. A non-maskable trap comes next, and its old context is the level-0 context. hold_o stays high throughout.
- R9: If nmi_i is low at that point, the block returns to idle with hold_o 0 and bus_status_o 3'b000.
- R10: bus_status_o is 3'b010 during every vector read and context write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset, also the power-up hold |
| req_i | input | 1 | Maskable interrupt accepted by the arbiter |
| req_level_i | input | 4 | Level of the maskable request |
| req_mask_i | input | 4 | Mask value to load for the maskable request |
| instr_done_i | input | 1 | Current instruction has completed |
| nmi_i | input | 1 | Non-maskable request pending |
| cur_wp_i | input | 16 | Processor workspace pointer |
| cur_pc_i | input | 16 | Processor program counter |
| cur_st_i | input | 16 | Processor status word |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_rdy_i | input | 1 | Access completes on this edge |
| bus_status_o | output | 3 | 000 run, 001 discarded fetch, 010 switch, 111 reset |
| hold_o | output | 1 | Processor must not execute |
| done_o | output | 1 | New context valid, one cycle |
| new_wp_o | output | 16 | New workspace pointer |
| new_pc_o | output | 16 | New program counter |
| new_st_o | output | 16 | New status word |

## Verification
A corrupted step state shows on the bus at the next access. The address sequence would skip a slot, repeat one or go out of order, and the first wrong address or strobe would be visible at the ready that follows. A wrong vector or captured workspace pointer appears within two accesses, as store addresses that are not W+26..W+30. A stale old-context register shows up as the wrong write data on the store that uses it. A wrong trap-kind flag shows up one access after the level-0 routine finishes: the discarded fetch is missing, or it appears after a trap where it should not.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RD_WP, S_RD_PC, S_WR13, S_WR14, S_WR15, S_FETCH
  } ctx_state_e;

  typedef enum logic [1:0] {K_BOOT, K_NMI, K_MASK} trap_kind_e;

  localparam logic [2:0] BS_RUN    = 3'b000;
  localparam logic [2:0] BS_FETCH  = 3'b001;
  localparam logic [2:0] BS_SWITCH = 3'b010;
  localparam logic [2:0] BS_RESET  = 3'b111;
endpackage

// File: rtl/ctx_ctrl.sv
module ctx_ctrl
  import ctx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       instr_done_i,
  input  logic       nmi_i,
  input  logic       mem_rdy_i,
  output ctx_state_e state_o,
  output logic       start_o,
  output trap_kind_e start_kind_o,
  output logic       cap_wp_o,
  output logic       cap_pc_o,
  output logic       fin_o,
  output logic       chain_o,
  output logic       hold_o,
  output logic [2:0] bus_status_o
);
  ctx_state_e state_q, state_d;
  trap_kind_e kind_q;
  logic       boot_q;

  always_comb begin
    start_o      = 1'b0;
    start_kind_o = K_MASK;
    if (state_q == S_IDLE) begin
      if (boot_q) begin
        start_o      = 1'b1;
        start_kind_o = K_BOOT;
      end else if (instr_done_i && nmi_i) begin
        start_o      = 1'b1;
        start_kind_o = K_NMI;
      end else if (instr_done_i && req_i) begin
        start_o      = 1'b1;
        start_kind_o = K_MASK;
      end
    end
  end

  assign cap_wp_o = (state_q == S_RD_WP) && mem_rdy_i;
  assign cap_pc_o = (state_q == S_RD_PC) && mem_rdy_i;
  assign fin_o    = (state_q == S_WR15)  && mem_rdy_i;
  assign chain_o  = (state_q == S_FETCH) && mem_rdy_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_o)   state_d = S_RD_WP;
      S_RD_WP: if (mem_rdy_i) state_d = S_RD_PC;
      S_RD_PC: if (mem_rdy_i) state_d = S_WR13;
      S_WR13:  if (mem_rdy_i) state_d = S_WR14;
      S_WR14:  if (mem_rdy_i) state_d = S_WR15;
      S_WR15:  if (mem_rdy_i) state_d = (kind_q == K_BOOT && nmi_i) ? S_FETCH : S_IDLE;
      S_FETCH: if (mem_rdy_i) state_d = S_RD_WP;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= K_BOOT;
      boot_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      if (start_o) begin
        kind_q <= start_kind_o;
        boot_q <= 1'b0;
      end else if (chain_o) begin
        kind_q <= K_NMI;
      end
    end
  end

  assign state_o = state_q;
  assign hold_o  = boot_q || (state_q != S_IDLE);

  always_comb begin
    if (state_q == S_IDLE)       bus_status_o = boot_q ? BS_RESET : BS_RUN;
    else if (state_q == S_FETCH) bus_status_o = BS_FETCH;
    else                         bus_status_o = BS_SWITCH;
  end

  // R3: the R15 store is only ever reached from the R14 store
  a_r3_store_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WR15 && $past(state_q) != S_WR15) |-> $past(state_q) == S_WR14);

  // R8: the discarded fetch belongs to the level-0 trap only
  a_r8_fetch_after_boot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FETCH) |-> (kind_q == K_BOOT));
endmodule

// File: rtl/ctx_bus_mux.sv
module ctx_bus_mux
  import ctx_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ctx_state_e    state_i,
  input  logic          mem_rdy_i,
  input  logic [DW-1:0] vec_base_i,
  input  logic [DW-1:0] new_wp_i,
  input  logic [DW-1:0] new_pc_i,
  input  logic [DW-1:0] old_wp_i,
  input  logic [DW-1:0] old_pc_i,
  input  logic [DW-1:0] old_st_i,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o
);
  localparam int            WORD_B = 2;
  localparam logic [DW-1:0] R13_OFF = DW'(13 * WORD_B);
  localparam logic [DW-1:0] R14_OFF = DW'(14 * WORD_B);
  localparam logic [DW-1:0] R15_OFF = DW'(15 * WORD_B);
  localparam logic [DW-1:0] PC_OFF  = DW'(WORD_B);

  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_rd_o    = 1'b0;
    mem_wr_o    = 1'b0;
    unique case (state_i)
      S_RD_WP: begin mem_rd_o = 1'b1; mem_addr_o = vec_base_i; end
      S_RD_PC: begin mem_rd_o = 1'b1; mem_addr_o = vec_base_i + PC_OFF; end
      S_WR13:  begin mem_wr_o = 1'b1; mem_addr_o = new_wp_i + R13_OFF; mem_wdata_o = old_wp_i; end
      S_WR14:  begin mem_wr_o = 1'b1; mem_addr_o = new_wp_i + R14_OFF; mem_wdata_o = old_pc_i; end
      S_WR15:  begin mem_wr_o = 1'b1; mem_addr_o = new_wp_i + R15_OFF; mem_wdata_o = old_st_i; end
      S_FETCH: begin mem_rd_o = 1'b1; mem_addr_o = new_pc_i; end
      default: ;
    endcase
  end

  a_r3_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  a_r4_hold_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_rd_o || mem_wr_o) && !mem_rdy_i) |=>
      ($stable(mem_addr_o) && $stable(mem_wdata_o) && $stable(mem_wr_o) && $stable(mem_rd_o)));
endmodule

// File: rtl/ctx_regs.sv
module ctx_regs
  import ctx_pkg::*;
#(
  parameter int            DW      = 16,
  parameter int            LW      = 4,
  parameter int            MW      = 4,
  parameter logic [DW-1:0] NMI_VEC = 16'hFFFC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  trap_kind_e    start_kind_i,
  input  logic [LW-1:0] req_level_i,
  input  logic [MW-1:0] req_mask_i,
  input  logic [DW-1:0] cur_wp_i,
  input  logic [DW-1:0] cur_pc_i,
  input  logic [DW-1:0] cur_st_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          cap_wp_i,
  input  logic          cap_pc_i,
  input  logic          fin_i,
  input  logic          chain_i,
  output logic [DW-1:0] vec_base_o,
  output logic [DW-1:0] new_wp_o,
  output logic [DW-1:0] new_pc_o,
  output logic [DW-1:0] old_wp_o,
  output logic [DW-1:0] old_pc_o,
  output logic [DW-1:0] old_st_o,
  output logic          done_o,
  output logic [DW-1:0] out_wp_o,
  output logic [DW-1:0] out_pc_o,
  output logic [DW-1:0] out_st_o
);
  localparam int VEC_SH = 2;

  logic [DW-1:0] vec_q, nwp_q, npc_q, owp_q, opc_q, ost_q;
  logic [MW-1:0] mask_q;
  logic [DW-1:0] st_nxt;
  logic          done_q;
  logic [DW-1:0] owp_r, opc_r, ost_r;

  assign st_nxt = {ost_q[DW-1:MW], mask_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q  <= '0;
      nwp_q  <= '0;
      npc_q  <= '0;
      owp_q  <= '0;
      opc_q  <= '0;
      ost_q  <= '0;
      mask_q <= '0;
      done_q <= 1'b0;
      owp_r  <= '0;
      opc_r  <= '0;
      ost_r  <= '0;
    end else begin
      done_q <= fin_i;
      if (start_i) begin
        owp_q <= cur_wp_i;
        opc_q <= cur_pc_i;
        ost_q <= cur_st_i;
        unique case (start_kind_i)
          K_BOOT:  begin vec_q <= '0;      mask_q <= '0; end
          K_NMI:   begin vec_q <= NMI_VEC; mask_q <= '0; end
          default: begin vec_q <= DW'(req_level_i) << VEC_SH; mask_q <= req_mask_i; end
        endcase
      end else if (chain_i) begin
        // level-0 context becomes the one saved by the NMI trap
        owp_q  <= nwp_q;
        opc_q  <= npc_q;
        ost_q  <= st_nxt;
        vec_q  <= NMI_VEC;
        mask_q <= '0;
      end
      if (cap_wp_i) nwp_q <= mem_rdata_i;
      if (cap_pc_i) npc_q <= mem_rdata_i;
      if (fin_i) begin
        owp_r <= nwp_q;
        opc_r <= npc_q;
        ost_r <= st_nxt;
      end
    end
  end

  assign vec_base_o = vec_q;
  assign new_wp_o   = nwp_q;
  assign new_pc_o   = npc_q;
  assign old_wp_o   = owp_q;
  assign old_pc_o   = opc_q;
  assign old_st_o   = ost_q;
  assign done_o     = done_q;
  assign out_wp_o   = owp_r;
  assign out_pc_o   = opc_r;
  assign out_st_o   = ost_r;

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/ctx_switch_seq.sv
module ctx_switch_seq
  import ctx_pkg::*;
#(
  parameter int            DW      = 16,
  parameter int            LW      = 4,
  parameter int            MW      = 4,
  parameter logic [DW-1:0] NMI_VEC = 16'hFFFC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [LW-1:0] req_level_i,
  input  logic [MW-1:0] req_mask_i,
  input  logic          instr_done_i,
  input  logic          nmi_i,
  input  logic [DW-1:0] cur_wp_i,
  input  logic [DW-1:0] cur_pc_i,
  input  logic [DW-1:0] cur_st_i,
  output logic [DW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  input  logic          mem_rdy_i,
  output logic [2:0]    bus_status_o,
  output logic          hold_o,
  output logic          done_o,
  output logic [DW-1:0] new_wp_o,
  output logic [DW-1:0] new_pc_o,
  output logic [DW-1:0] new_st_o
);
  ctx_state_e    state;
  trap_kind_e    start_kind;
  logic          start, cap_wp, cap_pc, fin, chain;
  logic [DW-1:0] vec_base, nwp, npc, owp, opc, ost;

  ctx_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .instr_done_i (instr_done_i),
    .nmi_i        (nmi_i),
    .mem_rdy_i    (mem_rdy_i),
    .state_o      (state),
    .start_o      (start),
    .start_kind_o (start_kind),
    .cap_wp_o     (cap_wp),
    .cap_pc_o     (cap_pc),
    .fin_o        (fin),
    .chain_o      (chain),
    .hold_o       (hold_o),
    .bus_status_o (bus_status_o)
  );

  ctx_regs #(.DW(DW), .LW(LW), .MW(MW), .NMI_VEC(NMI_VEC)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .start_kind_i (start_kind),
    .req_level_i  (req_level_i),
    .req_mask_i   (req_mask_i),
    .cur_wp_i     (cur_wp_i),
    .cur_pc_i     (cur_pc_i),
    .cur_st_i     (cur_st_i),
    .mem_rdata_i  (mem_rdata_i),
    .cap_wp_i     (cap_wp),
    .cap_pc_i     (cap_pc),
    .fin_i        (fin),
    .chain_i      (chain),
    .vec_base_o   (vec_base),
    .new_wp_o     (nwp),
    .new_pc_o     (npc),
    .old_wp_o     (owp),
    .old_pc_o     (opc),
    .old_st_o     (ost),
    .done_o       (done_o),
    .out_wp_o     (new_wp_o),
    .out_pc_o     (new_pc_o),
    .out_st_o     (new_st_o)
  );

  ctx_bus_mux #(.DW(DW)) u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .mem_rdy_i   (mem_rdy_i),
    .vec_base_i  (vec_base),
    .new_wp_i    (nwp),
    .new_pc_i    (npc),
    .old_wp_i    (owp),
    .old_pc_i    (opc),
    .old_st_i    (ost),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o)
  );

  // R1: quiet bus while the boot trap is still pending
  a_r1_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_status_o == BS_RESET) |-> !(mem_rd_o || mem_wr_o || done_o));
endmodule

// File: tb/ctx_switch_seq_test.sv
module ctx_switch_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, idone = 1'b0, nmi = 1'b0, rdy = 1'b0;
  logic [3:0]  lvl = '0, msk = '0;
  logic [15:0] cwp = '0, cpc = '0, cst = '0;
  logic [15:0] maddr, mwdata, mrdata, nwp, npc, nst;
  logic        mrd, mwr, hold, done;
  logic [2:0]  bstat;

  always #5 clk = ~clk;

  assign mrdata = maddr ^ 16'hA5C0;

  ctx_switch_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_level_i(lvl), .req_mask_i(msk),
    .instr_done_i(idone), .nmi_i(nmi), .cur_wp_i(cwp), .cur_pc_i(cpc), .cur_st_i(cst),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_rdata_i(mrdata), .mem_rd_o(mrd),
    .mem_wr_o(mwr), .mem_rdy_i(rdy), .bus_status_o(bstat), .hold_o(hold), .done_o(done),
    .new_wp_o(nwp), .new_pc_o(npc), .new_st_o(nst)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, wait_cfg = 0, acc_cnt = 0;
  int lg_n = 0, dn_n = 0, unstable = 0, dn_wide = 0, hold_gap = 0;
  bit dn_prev = 1'b0, ended = 1'b0;
  logic [15:0] acc_addr = '0;
  logic [15:0] lg_addr[16], lg_data[16];
  logic        lg_wr[16];
  logic [2:0]  lg_bs[16];
  logic [15:0] dn_wp[4], dn_pc[4], dn_st[4];

  function automatic logic [15:0] memf(input logic [15:0] a);
    return a ^ 16'hA5C0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // memory responder and monitor, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (done) begin
      if (dn_prev) dn_wide++;
      if (dn_n < 4) begin
        dn_wp[dn_n] = nwp; dn_pc[dn_n] = npc; dn_st[dn_n] = nst;
      end
      dn_n++;
    end
    dn_prev = done;
    if (dn_n == 1 && !hold && rst_n) hold_gap++;
    if (mrd || mwr) begin
      if (acc_cnt > 0 && maddr != acc_addr) unstable++;
      acc_addr = maddr;
      if (acc_cnt == wait_cfg) begin
        rdy = 1'b1;
        acc_cnt = 0;
        if (lg_n < 16) begin
          lg_addr[lg_n] = maddr; lg_data[lg_n] = mwdata; lg_wr[lg_n] = mwr; lg_bs[lg_n] = bstat;
        end
        lg_n++;
      end else begin
        rdy = 1'b0;
        acc_cnt++;
      end
    end else begin
      rdy = 1'b0;
      acc_cnt = 0;
    end
    if (cyc > 20000 && !ended) begin
      ended = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      summary();
    end
  end

  task automatic clr();
    lg_n = 0; dn_n = 0; unstable = 0; dn_wide = 0; hold_gap = 0;
  endtask

  task automatic wait_dn(input int n, input string tag);
    int t = 0;
    while (dn_n < n && t < 2000) begin @(negedge clk); t++; end
    @(negedge clk);
    chk(dn_n == n, {tag, " done count"}, dn_n, n);
  endtask

  task automatic chk_trap(input int b, input string tag, input logic [15:0] vec,
                          input logic [15:0] owp, input logic [15:0] opc, input logic [15:0] ost);
    logic [15:0] w = memf(vec);
    chk(lg_addr[b] == vec && !lg_wr[b], {tag, " R3 wp read"}, lg_addr[b], vec);
    chk(lg_addr[b+1] == vec + 16'd2 && !lg_wr[b+1], {tag, " R3 pc read"}, lg_addr[b+1], vec + 16'd2);
    chk(lg_addr[b+2] == w + 16'd26 && lg_wr[b+2], {tag, " R3 r13 addr"}, lg_addr[b+2], w + 16'd26);
    chk(lg_addr[b+3] == w + 16'd28 && lg_wr[b+3], {tag, " R3 r14 addr"}, lg_addr[b+3], w + 16'd28);
    chk(lg_addr[b+4] == w + 16'd30 && lg_wr[b+4], {tag, " R3 r15 addr"}, lg_addr[b+4], w + 16'd30);
    chk(lg_data[b+2] == owp, {tag, " R3 r13 data"}, lg_data[b+2], owp);
    chk(lg_data[b+3] == opc, {tag, " R3 r14 data"}, lg_data[b+3], opc);
    chk(lg_data[b+4] == ost, {tag, " R3 r15 data"}, lg_data[b+4], ost);
    for (int k = 0; k < 5; k++)
      chk(lg_bs[b+k] == 3'b010, {tag, " R10 switch status"}, lg_bs[b+k], 3'b010);
  endtask

  task automatic t_reset(input string tag);
    repeat (3) @(negedge clk);
    chk(bstat == 3'b111, {tag, " R1 status"}, bstat, 3'b111);
    chk(hold == 1'b1, {tag, " R1 hold"}, hold, 1);
    chk(!mrd && !mwr && !done, {tag, " R1 quiet"}, {mrd, mwr, done}, 0);
  endtask

  task automatic t_boot_plain();
    cwp = 16'h1111; cpc = 16'h2222; cst = 16'h3F5A; nmi = 1'b0; idone = 1'b0;
    t_reset("boot");
    clr();
    rst_n = 1'b1;
    wait_dn(1, "boot R2");
    chk(lg_n == 5, "boot R9 access count", lg_n, 5);
    chk(lg_addr[0] == 16'h0000 && lg_addr[1] == 16'h0002, "boot R2 vector", {lg_addr[0], lg_addr[1]}, 32'h0000_0002);
    chk_trap(0, "boot", 16'h0000, 16'h1111, 16'h2222, 16'h3F5A);
    chk(dn_wp[0] == 16'hA5C0, "boot R7 new wp", dn_wp[0], 16'hA5C0);
    chk(dn_pc[0] == 16'hA5C2, "boot R7 new pc", dn_pc[0], 16'hA5C2);
    chk(dn_st[0] == 16'h3F50, "boot R7 new st", dn_st[0], 16'h3F50);
    repeat (2) @(negedge clk);
    chk(hold == 1'b0 && bstat == 3'b000, "boot R9 idle", {hold, bstat}, 0);
    chk(lg_n == 5, "boot R9 no fetch", lg_n, 5);
    chk(dn_wide == 0, "boot R7 pulse width", dn_wide, 0);
  endtask

  task automatic t_maskable();
    clr();
    wait_cfg = 2;
    cwp = 16'h4000; cpc = 16'h4100; cst = 16'hC00F;
    req = 1'b1; lvl = 4'd5; msk = 4'd4; idone = 1'b0;
    repeat (6) @(negedge clk);
    chk(lg_n == 0 && hold == 1'b0, "mask R5 waits for boundary", lg_n, 0);
    idone = 1'b1;
    @(negedge clk);
    chk(hold == 1'b1, "mask R5 accepted", hold, 1);
    req = 1'b0; idone = 1'b0;
    cwp = 16'hDEAD; cpc = 16'hBEEF; cst = 16'hFFFF;
    wait_dn(1, "mask R7");
    chk_trap(0, "mask R5", 16'h0014, 16'h4000, 16'h4100, 16'hC00F);
    chk(unstable == 0, "mask R4 access held", unstable, 0);
    chk(lg_n == 5, "mask R4 access count", lg_n, 5);
    chk(dn_wp[0] == 16'hA5D4 && dn_pc[0] == 16'hA5D6, "mask R7 new wp/pc", {dn_wp[0], dn_pc[0]}, 32'hA5D4_A5D6);
    chk(dn_st[0] == 16'hC004, "mask R7 new st", dn_st[0], 16'hC004);
    wait_cfg = 0;
  endtask

  task automatic t_nmi_prio();
    clr();
    cwp = 16'h6000; cpc = 16'h6100; cst = 16'h1237;
    req = 1'b1; lvl = 4'd3; msk = 4'd2; nmi = 1'b1; idone = 1'b1;
    @(negedge clk);
    req = 1'b0; nmi = 1'b0; idone = 1'b0;
    wait_dn(1, "nmi R6");
    chk_trap(0, "nmi R6", 16'hFFFC, 16'h6000, 16'h6100, 16'h1237);
    chk(dn_wp[0] == 16'h5A3C && dn_pc[0] == 16'h5A3E, "nmi R6 new wp/pc", {dn_wp[0], dn_pc[0]}, 32'h5A3C_5A3E);
    chk(dn_st[0] == 16'h1230, "nmi R6 mask zero", dn_st[0], 16'h1230);
  endtask

  task automatic t_boot_nmi();
    @(negedge clk);
    rst_n = 1'b0;
    cwp = 16'h7000; cpc = 16'h7100; cst = 16'h89AB; nmi = 1'b1; idone = 1'b0;
    t_reset("reboot");
    clr();
    rst_n = 1'b1;
    wait_dn(2, "bootnmi R8");
    nmi = 1'b0;
    chk(lg_n == 11, "bootnmi R8 access count", lg_n, 11);
    chk_trap(0, "bootnmi lvl0", 16'h0000, 16'h7000, 16'h7100, 16'h89AB);
    chk(lg_addr[5] == 16'hA5C2 && !lg_wr[5], "bootnmi R8 fetch addr", lg_addr[5], 16'hA5C2);
    chk(lg_bs[5] == 3'b001, "bootnmi R8 fetch status", lg_bs[5], 3'b001);
    chk_trap(6, "bootnmi R8 chained", 16'hFFFC, 16'hA5C0, 16'hA5C2, 16'h89A0);
    chk(dn_wp[0] == 16'hA5C0 && dn_pc[0] == 16'hA5C2, "bootnmi R7 lvl0 ctx", {dn_wp[0], dn_pc[0]}, 32'hA5C0_A5C2);
    chk(dn_wp[1] == 16'h5A3C && dn_pc[1] == 16'h5A3E, "bootnmi R8 nmi ctx", {dn_wp[1], dn_pc[1]}, 32'h5A3C_5A3E);
    chk(dn_st[1] == 16'h89A0, "bootnmi R8 nmi st", dn_st[1], 16'h89A0);
    chk(hold_gap == 0, "bootnmi R8 hold kept", hold_gap, 0);
    chk(dn_wide == 0, "bootnmi R7 pulse width", dn_wide, 0);
  endtask

  initial begin
    t_boot_plain();
    t_maskable();
    t_nmi_prio();
    t_boot_nmi();
    ended = 1'b1;
    summary();
  end
endmodule